// File: doc/BRIEF.md
# Two-Channel Block-Cipher Job Controller

This unit is the register-mapped front end of a 128-bit block-cipher accelerator. Software programs one of two job channels with a source address, a destination address and a byte count. It loads a 128-bit key and a 128-bit chaining vector, then sets the start bit of the channel's control word. The unit then walks the job one 16-byte block at a time. It reads each block through a request/grant memory port and hands it to an external single-block cipher through a request/acknowledge port. It applies cipher-block chaining itself when that mode is selected, and writes the result to the destination. When the last block is stored, the start bit falls, so software can poll for completion. A completion flag is also raised, and it can drive an interrupt.

The same register space carries an interrupt mask/flag word with three sources: channel A, channel B and an external nonvolatile-memory done pulse. It also carries a random-sample data/status pair that is filled from an entropy input. The cipher core and the memory are outside the unit and appear only as ports. Register reads are combinational from `reg_addr` and `reg_rd`. Register writes take effect at the clock edge.

Top module: `blkciph_offload`

## Requirements
- R1: Register offsets are: control A 0x00, control B 0x04, interrupt word 0x08, A source/destination/length 0x10/0x14/0x18, B source/destination/length 0x20/0x24/0x28, key words 0x30-0x3C, chaining-vector words 0x40-0x4C, random data 0x50, random status 0x54. Word j of the key or vector holds bits 32j+31..32j. Address, length and vector words read back what was written. After reset every control word and the random status read 0.
- R2: Control bit 0 (start) stays 1 while a job runs. It reads 0 once every block up to the programmed length has been written. At that point the channel's completion flag is set: bit 16 for A, bit 17 for B. A job with length 0 completes with no memory traffic.
- R3: With control bit 5 = 0 (ECB), each destination block is the cipher output for the matching source block. Control bit 1 drives the cipher's direction (1 = encrypt, 0 = decrypt).
- R4: CBC encrypt (bit 5 = 1, bit 1 = 1): each block is XORed with the current vector before the cipher. The output becomes the next vector.
- R5: CBC decrypt (bit 5 = 1, bit 1 = 0): the cipher output is XORed with the current vector. The input block becomes the next vector.
- R6: After a CBC job the vector registers hold the final chaining value. An ECB job leaves them unchanged.
- R7: Control bit 2 = 1 makes the job use the written key. With bit 2 = 0 the job uses the FIXED_KEY parameter. Key offsets always read 0.
- R8: A start with a length, source or destination whose low four bits are not zero clears start at once. It sets sticky error bit 6 and makes no memory request. Writing a control word with bit 6 = 1 clears the error.
- R9: In the interrupt word, bits 0/1/2 disable A/B/nonvolatile completion and bits 16/17/18 are the matching flags. Flags are cleared by writing 1 to them, and `irq` is high when any flag is set with its disable bit clear. After reset the disable bits read 1. Writing 0x00070007 masks all sources and clears all flags.
- R10: Channel A has priority when both are pending. Channel B issues no memory request while channel A's start bit is 1.
- R11: A write to a control word while its start bit is 1 is ignored.
- R12: An entropy sample sets random status bit 0 and loads the random data word. A read of the random data clears bit 0 unless a new sample arrives in the same cycle.
- R13: Memory and cipher requests stay asserted with stable address and data until granted or acknowledged. Memory addresses are always 16-byte aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on random data) |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 128 | Block to store |
| mem_gnt | input | 1 | Memory grant; read data valid with it |
| mem_rdata | input | 128 | Block read from memory |
| cph_req | output | 1 | Cipher request |
| cph_enc | output | 1 | Cipher direction, 1 = encrypt |
| cph_key | output | 128 | Key for the cipher |
| cph_din | output | 128 | Block into the cipher |
| cph_ack | input | 1 | Cipher done; result valid with it |
| cph_dout | input | 128 | Block from the cipher |
| rng_valid_in | input | 1 | Entropy sample strobe |
| rng_word_in | input | 32 | Entropy sample |
| nvm_done | input | 1 | Nonvolatile-memory operation done pulse |
| irq | output | 1 | Interrupt request |

## Verification
The assertions watch the port handshakes and address alignment on every cycle. They also check that memory traffic only occurs for a channel whose start bit is set, that B never wins arbitration while A is pending, and that the mask-all write silences `irq`. The chaining arithmetic of both CBC directions, the final vector value, the key selection, the error path, ignored control writes and the random-read side effect can only be shown by the bench's scenarios. The bench compares memory contents and register reads against its own model of the cipher and chaining.

// File: rtl/bco_pkg.sv
// Shared constants and types for the block-cipher job controller.
// Assumes byte offsets within an 8-bit or wider register window.
package bco_pkg;
    localparam int DATA_W    = 32;
    localparam int BLK_W     = 128;
    localparam int MADDR_W   = 32;
    localparam int BLK_BYTES = BLK_W / 8;
    localparam int OFS_W     = $clog2(BLK_BYTES);
    localparam int N_CH      = 2;
    localparam int N_WORDS   = BLK_W / DATA_W;

    localparam int OFF_CTL0  = 'h00;
    localparam int OFF_IRQ   = 'h08;
    localparam int OFF_CH0   = 'h10;
    localparam int CH_STRIDE = 'h10;
    localparam int OFF_KEY   = 'h30;
    localparam int OFF_IV    = 'h40;
    localparam int OFF_RNG   = 'h50;
    localparam int OFF_RNGST = 'h54;

    typedef struct packed {
        logic err;
        logic cbc;
        logic sc;
        logic dc;
        logic wk;
        logic enc;
        logic go;
    } ctl_t;

    typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_CPH, ST_WR} eng_st_t;
endpackage

// File: rtl/bco_regs.sv
// Register file: per-channel job registers, key, chaining vector,
// interrupt mask/flags and random sample pair. Reads are combinational.
// Assumes the engine raises fin_i/err_i only for channels with go set.
module bco_regs
    import bco_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic                          reg_rd,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [DATA_W-1:0]             reg_wdata,
    output logic [DATA_W-1:0]             reg_rdata,
    input  logic                          rng_valid_in,
    input  logic [DATA_W-1:0]             rng_word_in,
    input  logic                          nvm_done,
    output logic [N_CH-1:0]               ch_go,
    output logic [N_CH-1:0]               ch_enc,
    output logic [N_CH-1:0]               ch_wk,
    output logic [N_CH-1:0]               ch_cbc,
    output logic [N_CH-1:0][MADDR_W-1:0]  ch_src,
    output logic [N_CH-1:0][MADDR_W-1:0]  ch_dst,
    output logic [N_CH-1:0][MADDR_W-1:0]  ch_len,
    output logic [BLK_W-1:0]              key_q,
    output logic [BLK_W-1:0]              iv_q,
    input  logic [N_CH-1:0]               fin_i,
    input  logic [N_CH-1:0]               err_i,
    input  logic                          iv_we,
    input  logic [BLK_W-1:0]              iv_nxt,
    output logic                          irq
);
    ctl_t [N_CH-1:0] ctl_q;
    logic [2:0]      mask_q;
    logic [2:0]      flag_q;
    logic [2:0]      flag_set;
    logic [DATA_W-1:0] rng_q;
    logic            rng_vld_q;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
        return a == ADDR_W'(off);
    endfunction

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        localparam int CTL_OFF = OFF_CTL0 + 4 * c;
        localparam int BASE    = OFF_CH0 + CH_STRIDE * c;

        // Control word: start/err updated by engine, software writes when idle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctl_q[c] <= '0;
            end else begin
                if (fin_i[c]) ctl_q[c].go <= 1'b0;
                if (err_i[c]) begin
                    ctl_q[c].go  <= 1'b0;
                    ctl_q[c].err <= 1'b1;
                end
                if (reg_wr && hit(reg_addr, CTL_OFF) && !ctl_q[c].go) begin
                    ctl_q[c][5:0] <= reg_wdata[5:0];
                    if (reg_wdata[6]) ctl_q[c].err <= 1'b0;
                end
            end
        end

        // Job address and length registers.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ch_src[c] <= '0;
                ch_dst[c] <= '0;
                ch_len[c] <= '0;
            end else if (reg_wr) begin
                if (hit(reg_addr, BASE))     ch_src[c] <= reg_wdata;
                if (hit(reg_addr, BASE + 4)) ch_dst[c] <= reg_wdata;
                if (hit(reg_addr, BASE + 8)) ch_len[c] <= reg_wdata;
            end
        end

        assign ch_go[c]  = ctl_q[c].go;
        assign ch_enc[c] = ctl_q[c].enc;
        assign ch_wk[c]  = ctl_q[c].wk;
        assign ch_cbc[c] = ctl_q[c].cbc;
    end

    // Key and chaining vector words; engine update of the vector wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q <= '0;
            iv_q  <= '0;
        end else begin
            for (int w = 0; w < N_WORDS; w++) begin
                if (reg_wr && hit(reg_addr, OFF_KEY + 4 * w))
                    key_q[w*DATA_W +: DATA_W] <= reg_wdata;
                if (reg_wr && hit(reg_addr, OFF_IV + 4 * w))
                    iv_q[w*DATA_W +: DATA_W] <= reg_wdata;
            end
            if (iv_we) iv_q <= iv_nxt;
        end
    end

    assign flag_set = {nvm_done, fin_i};

    // Interrupt mask and write-one-to-clear flags; a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 3'b111;
            flag_q <= '0;
        end else if (reg_wr && hit(reg_addr, OFF_IRQ)) begin
            mask_q <= reg_wdata[2:0];
            flag_q <= (flag_q & ~reg_wdata[18:16]) | flag_set;
        end else begin
            flag_q <= flag_q | flag_set;
        end
    end

    assign irq = |(flag_q & ~mask_q);

    // Random sample holding register; a data read consumes the sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rng_q     <= '0;
            rng_vld_q <= 1'b0;
        end else if (rng_valid_in) begin
            rng_q     <= rng_word_in;
            rng_vld_q <= 1'b1;
        end else if (reg_rd && hit(reg_addr, OFF_RNG)) begin
            rng_vld_q <= 1'b0;
        end
    end

    // Read multiplexer; key words and unmapped offsets return zero.
    always_comb begin
        reg_rdata = '0;
        for (int c = 0; c < N_CH; c++) begin
            if (hit(reg_addr, OFF_CTL0 + 4 * c)) reg_rdata = DATA_W'(ctl_q[c]);
            if (hit(reg_addr, OFF_CH0 + CH_STRIDE * c))     reg_rdata = ch_src[c];
            if (hit(reg_addr, OFF_CH0 + CH_STRIDE * c + 4)) reg_rdata = ch_dst[c];
            if (hit(reg_addr, OFF_CH0 + CH_STRIDE * c + 8)) reg_rdata = ch_len[c];
        end
        for (int w = 0; w < N_WORDS; w++) begin
            if (hit(reg_addr, OFF_IV + 4 * w)) reg_rdata = iv_q[w*DATA_W +: DATA_W];
        end
        if (hit(reg_addr, OFF_IRQ))
            reg_rdata = {13'b0, flag_q, 13'b0, mask_q};
        if (hit(reg_addr, OFF_RNG))   reg_rdata = rng_q;
        if (hit(reg_addr, OFF_RNGST)) reg_rdata = {31'b0, rng_vld_q};
    end
endmodule

// File: rtl/bco_engine.sv
// Job engine: arbitrates channels (A first), validates the job, then for
// each block reads memory, runs the external cipher with CBC applied here,
// and writes back. Assumes the memory returns read data with its grant.
module bco_engine
    import bco_pkg::*;
#(
    parameter logic [BLK_W-1:0] FIXED_KEY = '0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_CH-1:0]               ch_go,
    input  logic [N_CH-1:0]               ch_enc,
    input  logic [N_CH-1:0]               ch_wk,
    input  logic [N_CH-1:0]               ch_cbc,
    input  logic [N_CH-1:0][MADDR_W-1:0]  ch_src,
    input  logic [N_CH-1:0][MADDR_W-1:0]  ch_dst,
    input  logic [N_CH-1:0][MADDR_W-1:0]  ch_len,
    input  logic [BLK_W-1:0]              key_q,
    input  logic [BLK_W-1:0]              iv_q,
    output logic [N_CH-1:0]               fin_o,
    output logic [N_CH-1:0]               err_o,
    output logic                          iv_we,
    output logic [BLK_W-1:0]              iv_nxt,
    output logic                          busy,
    output logic                          cur_ch,
    output logic                          mem_req,
    output logic                          mem_we,
    output logic [MADDR_W-1:0]            mem_addr,
    output logic [BLK_W-1:0]              mem_wdata,
    input  logic                          mem_gnt,
    input  logic [BLK_W-1:0]              mem_rdata,
    output logic                          cph_req,
    output logic                          cph_enc,
    output logic [BLK_W-1:0]              cph_key,
    output logic [BLK_W-1:0]              cph_din,
    input  logic                          cph_ack,
    input  logic [BLK_W-1:0]              cph_dout
);
    eng_st_t             st_q;
    logic                ch_q, enc_q, wk_q, cbc_q;
    logic [MADDR_W-1:0]  src_q, dst_q, len_q, off_q;
    logic [BLK_W-1:0]    blk_q, cv_q;
    logic                sel, bad, last;
    logic [BLK_W-1:0]    res;

    // Arbitration and job validation for the next pending channel.
    always_comb begin
        sel  = ch_go[0] ? 1'b0 : 1'b1;
        bad  = (ch_len[sel][OFS_W-1:0] != '0) || (ch_src[sel][OFS_W-1:0] != '0)
            || (ch_dst[sel][OFS_W-1:0] != '0);
        last = (off_q + MADDR_W'(BLK_BYTES)) == len_q;
        res  = (cbc_q && !enc_q) ? (cph_dout ^ cv_q) : cph_dout;
    end

    // Completion and error strobes back to the register file.
    always_comb begin
        fin_o = '0;
        err_o = '0;
        if (st_q == ST_IDLE && |ch_go) begin
            if (bad)                      err_o[sel] = 1'b1;
            else if (ch_len[sel] == '0)   fin_o[sel] = 1'b1;
        end
        if (st_q == ST_WR && mem_gnt && last) fin_o[ch_q] = 1'b1;
    end

    // Per-block sequence: read, cipher, write, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            ch_q  <= 1'b0;
            enc_q <= 1'b0;
            wk_q  <= 1'b0;
            cbc_q <= 1'b0;
            src_q <= '0;
            dst_q <= '0;
            len_q <= '0;
            off_q <= '0;
            blk_q <= '0;
            cv_q  <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (|ch_go && !bad && ch_len[sel] != '0) begin
                    ch_q  <= sel;
                    enc_q <= ch_enc[sel];
                    wk_q  <= ch_wk[sel];
                    cbc_q <= ch_cbc[sel];
                    src_q <= ch_src[sel];
                    dst_q <= ch_dst[sel];
                    len_q <= ch_len[sel];
                    off_q <= '0;
                    cv_q  <= iv_q;
                    st_q  <= ST_RD;
                end
                ST_RD: if (mem_gnt) begin
                    blk_q <= mem_rdata;
                    st_q  <= ST_CPH;
                end
                ST_CPH: if (cph_ack) begin
                    blk_q <= res;
                    if (cbc_q) cv_q <= enc_q ? res : blk_q;
                    st_q  <= ST_WR;
                end
                ST_WR: if (mem_gnt) begin
                    if (last) st_q <= ST_IDLE;
                    else begin
                        off_q <= off_q + MADDR_W'(BLK_BYTES);
                        st_q  <= ST_RD;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign iv_we     = (st_q == ST_CPH) && cph_ack && cbc_q;
    assign iv_nxt    = enc_q ? res : blk_q;
    assign busy      = st_q != ST_IDLE;
    assign cur_ch    = ch_q;
    assign mem_req   = (st_q == ST_RD) || (st_q == ST_WR);
    assign mem_we    = st_q == ST_WR;
    assign mem_addr  = ((st_q == ST_WR) ? dst_q : src_q) + off_q;
    assign mem_wdata = blk_q;
    assign cph_req   = st_q == ST_CPH;
    assign cph_enc   = enc_q;
    assign cph_key   = wk_q ? key_q : FIXED_KEY;
    assign cph_din   = (cbc_q && enc_q) ? (blk_q ^ cv_q) : blk_q;
endmodule

// File: rtl/blkciph_offload.sv
// Top of the block-cipher job controller: register file plus job engine.
// Assumes one outstanding memory and one outstanding cipher request.
module blkciph_offload
    import bco_pkg::*;
#(
    parameter int               ADDR_W    = 8,
    parameter logic [BLK_W-1:0] FIXED_KEY = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [31:0]        mem_addr,
    output logic [127:0]       mem_wdata,
    input  logic               mem_gnt,
    input  logic [127:0]       mem_rdata,
    output logic               cph_req,
    output logic               cph_enc,
    output logic [127:0]       cph_key,
    output logic [127:0]       cph_din,
    input  logic               cph_ack,
    input  logic [127:0]       cph_dout,
    input  logic               rng_valid_in,
    input  logic [31:0]        rng_word_in,
    input  logic               nvm_done,
    output logic               irq
);
    logic [N_CH-1:0]              ch_go, ch_enc, ch_wk, ch_cbc, fin, err;
    logic [N_CH-1:0][MADDR_W-1:0] ch_src, ch_dst, ch_len;
    logic [BLK_W-1:0]             key_q, iv_q, iv_nxt;
    logic                         iv_we, busy, cur_ch;

    bco_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rng_valid_in(rng_valid_in), .rng_word_in(rng_word_in), .nvm_done(nvm_done),
        .ch_go(ch_go), .ch_enc(ch_enc), .ch_wk(ch_wk), .ch_cbc(ch_cbc),
        .ch_src(ch_src), .ch_dst(ch_dst), .ch_len(ch_len),
        .key_q(key_q), .iv_q(iv_q), .fin_i(fin), .err_i(err),
        .iv_we(iv_we), .iv_nxt(iv_nxt), .irq(irq)
    );

    bco_engine #(.FIXED_KEY(FIXED_KEY)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .ch_go(ch_go), .ch_enc(ch_enc), .ch_wk(ch_wk), .ch_cbc(ch_cbc),
        .ch_src(ch_src), .ch_dst(ch_dst), .ch_len(ch_len),
        .key_q(key_q), .iv_q(iv_q), .fin_o(fin), .err_o(err),
        .iv_we(iv_we), .iv_nxt(iv_nxt), .busy(busy), .cur_ch(cur_ch),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .cph_req(cph_req), .cph_enc(cph_enc), .cph_key(cph_key),
        .cph_din(cph_din), .cph_ack(cph_ack), .cph_dout(cph_dout)
    );
endmodule

// File: rtl/bco_chk.sv
// Protocol and arbitration checker bound to the job controller top.
module bco_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              mem_req,
    input logic              mem_gnt,
    input logic              mem_we,
    input logic [31:0]       mem_addr,
    input logic              cph_req,
    input logic              cph_ack,
    input logic [127:0]      cph_din,
    input logic              irq,
    input logic              busy,
    input logic              cur_ch,
    input logic [1:0]        ch_go
);
    // R13
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));
    // R13
    cph_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cph_req && !cph_ack |=> cph_req && $stable(cph_din));
    // R13
    mem_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[3:0] == 4'h0);
    // R2
    traffic_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ch_go[cur_ch]);
    // R10
    a_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) && cur_ch |-> !$past(ch_go[0]));
    // R9
    mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == ADDR_W'(8'h08)
        && (reg_wdata & 32'h0007_0007) == 32'h0007_0007 |=> !irq);
endmodule

bind blkciph_offload bco_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_gnt(mem_gnt),
    .mem_we(mem_we), .mem_addr(mem_addr), .cph_req(cph_req),
    .cph_ack(cph_ack), .cph_din(cph_din), .irq(irq), .busy(busy),
    .cur_ch(cur_ch), .ch_go(ch_go)
);

// File: tb/tb_blkciph_offload.sv
module tb_blkciph_offload;
    localparam int CLK_PERIOD = 10;
    localparam logic [127:0] BENCH_FK = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
    localparam logic [127:0] KEY_W    = 128'hA1B2C3D4_E5F60718_293A4B5C_6D7E8F90;
    localparam logic [127:0] IV0      = 128'h00112233_44556677_8899AABB_CCDDEEFF;
    // [7] channel B, [6] written key, [5] CBC, [4] encrypt, [3:0] blocks
    localparam logic [7:0] VEC [7] = '{8'h52, 8'h41, 8'h73, 8'h63, 8'hB4, 8'hE2, 8'h01};

    logic clk = 0, rst_n = 0;
    logic reg_wr = 0, reg_rd = 0;
    logic [7:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic mem_req, mem_we, mem_gnt = 0;
    logic [31:0] mem_addr;
    logic [127:0] mem_wdata, mem_rdata = 0;
    logic cph_req, cph_enc, cph_ack = 0;
    logic [127:0] cph_key, cph_din, cph_dout = 0;
    logic rng_valid_in = 0, nvm_done = 0, irq;
    logic [31:0] rng_word_in = 0;

    logic [127:0] mem [64];
    int total = 0, fails = 0, gnt_cnt = 0, cyc = 0;
    int a_last_wr = 0, b_first_rd = 0;

    blkciph_offload #(.ADDR_W(8), .FIXED_KEY(BENCH_FK)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [127:0] f_enc(input logic [127:0] x, input logic [127:0] k);
        return {x[126:0], x[127]} ^ k;
    endfunction
    function automatic logic [127:0] f_dec(input logic [127:0] y, input logic [127:0] k);
        logic [127:0] t = y ^ k;
        return {t[0], t[127:1]};
    endfunction
    function automatic logic [127:0] pat(input int v, input int i);
        return {32'(v * 7 + i), 32'hDEADBEEF ^ 32'(i), 32'h5A5A0000 + 32'(v), 32'(i * 977 + 3)};
    endfunction

    initial forever begin : cyc_count
        @(posedge clk);
        cyc++;
    end

    // Memory model: grants one cycle after a request is seen.
    initial forever begin : mem_model
        @(negedge clk);
        if (mem_req && !mem_gnt) begin
            mem_gnt = 1;
            gnt_cnt++;
            if (mem_we) begin
                mem[mem_addr[9:4]] = mem_wdata;
                if (mem_addr >= 32'h200 && mem_addr < 32'h300) a_last_wr = cyc;
            end else begin
                mem_rdata = mem[mem_addr[9:4]];
                if (mem_addr >= 32'h100 && mem_addr < 32'h200 && b_first_rd == 0) b_first_rd = cyc;
            end
        end else mem_gnt = 0;
    end

    // Cipher model: rotate-and-XOR stand-in for the real core.
    initial forever begin : cph_model
        @(negedge clk);
        if (cph_req && !cph_ack) begin
            cph_ack  = 1;
            cph_dout = cph_enc ? f_enc(cph_din, cph_key) : f_dec(cph_din, cph_key);
        end else cph_ack = 0;
    end

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic wait_idle(input logic [7:0] ctl_off, input string tag);
        logic [31:0] d;
        int n = 0;
        do begin
            rd(ctl_off, d);
            n++;
        end while (d[0] && n < 2000);
        chk(!d[0], tag, {96'b0, d}, 128'h0);
    endtask

    task automatic run_vec(input logic [7:0] v, input int vi);
        bit chb = v[7], wk = v[6], cbc = v[5], enc = v[4];
        int nb = int'(v[3:0]);
        logic [7:0] base = chb ? 8'h20 : 8'h10;
        logic [7:0] coff = chb ? 8'h04 : 8'h00;
        int src = chb ? 'h100 : 'h000;
        int dst = chb ? 'h300 : 'h200;
        logic [127:0] k = wk ? KEY_W : BENCH_FK;
        logic [127:0] cv = IV0, p, c, x, ivr;
        logic [31:0] d;
        string tag;
        for (int i = 0; i < nb; i++) begin
            mem[(src >> 4) + i] = pat(vi, i);
            mem[(dst >> 4) + i] = '0;
        end
        for (int w = 0; w < 4; w++) begin
            wr(8'h30 + 8'(4 * w), KEY_W[32*w +: 32]);
            wr(8'h40 + 8'(4 * w), IV0[32*w +: 32]);
        end
        wr(base, 32'(src));
        wr(base + 8'h4, 32'(dst));
        wr(base + 8'h8, 32'(nb * 16));
        wr(coff, {26'b0, cbc, 2'b11, wk, enc, 1'b1});
        wait_idle(coff, "R2 start falls after job");
        for (int i = 0; i < nb; i++) begin
            p = pat(vi, i);
            if (enc) begin
                x = cbc ? (p ^ cv) : p;
                c = f_enc(x, k);
                if (cbc) cv = c;
            end else begin
                x = f_dec(p, k);
                c = cbc ? (x ^ cv) : x;
                if (cbc) cv = p;
            end
            tag = !wk ? "R7 fixed-key block" : !cbc ? "R3 ECB block" : enc ? "R4 CBC enc block" : "R5 CBC dec block";
            chk(mem[(dst >> 4) + i] === c, tag, mem[(dst >> 4) + i], c);
        end
        for (int w = 0; w < 4; w++) begin
            rd(8'h40 + 8'(4 * w), d);
            ivr[32*w +: 32] = d;
        end
        chk(ivr === cv, "R6 final vector", ivr, cv);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        int g0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(8'h00, d); chk(d == 0, "R1 reset ctrl A", {96'b0, d}, 0);
        rd(8'h54, d); chk(d == 0, "R1 reset rng status", {96'b0, d}, 0);
        rd(8'h08, d); chk(d == 32'h7, "R9 reset irq word", {96'b0, d}, 128'h7);
        chk(irq == 0, "R9 reset irq pin", {127'b0, irq}, 0);
        // R1 readback, R7 key reads zero
        wr(8'h24, 32'h0000_1230); rd(8'h24, d);
        chk(d == 32'h1230, "R1 B dest readback", {96'b0, d}, 128'h1230);
        wr(8'h34, 32'hFFFF_FFFF); rd(8'h34, d);
        chk(d == 0, "R7 key reads zero", {96'b0, d}, 0);

        for (int v = 0; v < 7; v++) run_vec(VEC[v], v);

        // R8 bad length then misaligned source
        g0 = gnt_cnt;
        wr(8'h10, 0); wr(8'h14, 32'h200); wr(8'h18, 32'h18);
        wr(8'h00, 32'h1);
        repeat (3) @(negedge clk);
        rd(8'h00, d); chk(d == 32'h40, "R8 bad length err", {96'b0, d}, 128'h40);
        wr(8'h18, 32'h10); wr(8'h10, 32'h8); wr(8'h00, 32'h1);
        repeat (3) @(negedge clk);
        rd(8'h00, d); chk(d == 32'h40, "R8 misaligned err", {96'b0, d}, 128'h40);
        chk(gnt_cnt == g0, "R8 no traffic", 128'(gnt_cnt), 128'(g0));
        wr(8'h00, 32'h40); rd(8'h00, d);
        chk(d == 0, "R8 err cleared", {96'b0, d}, 0);

        // R10/R11 priority and ignored control writes
        wr(8'h08, 32'h0007_0000);
        for (int i = 0; i < 4; i++) mem[i] = pat(20, i);
        mem[16] = pat(21, 0); mem[48] = '0;
        wr(8'h10, 0); wr(8'h14, 32'h200); wr(8'h18, 32'h40);
        wr(8'h20, 32'h100); wr(8'h24, 32'h300); wr(8'h28, 32'h10);
        a_last_wr = 0; b_first_rd = 0;
        wr(8'h00, 32'h1F);
        wr(8'h00, 32'h00);
        rd(8'h00, d); chk(d == 32'h1F, "R11 ctrl write ignored", {96'b0, d}, 128'h1F);
        wr(8'h04, 32'h1F);
        wait_idle(8'h00, "R2 A done");
        wait_idle(8'h04, "R2 B done");
        chk(b_first_rd > a_last_wr, "R10 B after A", 128'(b_first_rd), 128'(a_last_wr));
        chk(mem[48] === f_enc(pat(21, 0), KEY_W), "R10 B result", mem[48], f_enc(pat(21, 0), KEY_W));
        rd(8'h08, d); chk(d == 32'h0003_0000, "R9 both flags", {96'b0, d}, 128'h30000);
        chk(irq == 1, "R9 irq on flag", {127'b0, irq}, 1);

        // R9 clear, nonvolatile source, masking
        wr(8'h08, 32'h0003_0000);
        chk(irq == 0, "R9 W1C clears irq", {127'b0, irq}, 0);
        @(negedge clk); nvm_done = 1; @(negedge clk); nvm_done = 0;
        chk(irq == 1, "R9 nvm irq", {127'b0, irq}, 1);
        wr(8'h08, 32'h0007_0007);
        chk(irq == 0, "R9 mask all", {127'b0, irq}, 0);
        @(negedge clk); nvm_done = 1; @(negedge clk); nvm_done = 0;
        rd(8'h08, d); chk(d == 32'h0004_0007, "R9 masked flag held", {96'b0, d}, 128'h40007);
        chk(irq == 0, "R9 masked no irq", {127'b0, irq}, 0);

        // R12 random sample
        @(negedge clk); rng_valid_in = 1; rng_word_in = 32'hCAFE_F00D;
        @(negedge clk); rng_valid_in = 0;
        rd(8'h54, d); chk(d == 1, "R12 valid set", {96'b0, d}, 1);
        rd(8'h50, d); chk(d == 32'hCAFE_F00D, "R12 data", {96'b0, d}, 128'hCAFEF00D);
        rd(8'h54, d); chk(d == 0, "R12 valid cleared by read", {96'b0, d}, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule